// File: doc/BRIEF.md
# SPI Flash Command Engine

This block sits behind a small byte-wide register port and runs one serial flash command per request. Software loads the opcode, a packed pair of byte counts and up to eight payload bytes, then sets a start bit. The engine lowers chip select, shifts out the opcode and the payload, and clocks in the requested number of response bytes. It then raises chip select and clears the start bit.

Payload and response bytes share one eight-entry buffer that sits behind a single data port with an auto-incrementing pointer. The engine fetches the payload from the start of the buffer and writes each kept response byte directly after the payload. A read-back after a pointer reset therefore returns the payload bytes first and the response after them. If a command has no payload bytes, the engine discards the first received byte. Software then asks for one more receive byte than it needs.

The serial side works in SPI mode 0, sends the most significant bit first, and runs its serial clock at the system clock divided by `2*HALF_DIV`.

Top module: `spi_cmd_engine`

## Requirements
- R1: The byte at offset 0x0 is the opcode. It is the first byte shifted out, most significant bit first. MOSI changes only while SCLK is low.
- R2: The register at offset 0x1 holds the transmit count in bits [3:0] and the receive count in bits [7:4]. One command moves exactly 1 + transmit + receive bytes on the bus.
- R3: The payload bytes follow the opcode and come from buffer entries 0, 1, 2 and so on. A transmit count above 8 is treated as 8.
- R4: Writing a 1 to bit 0 of offset 0x2 starts a command. Bit 0 of offset 0x2 and bit 7 of offset 0x3 read 1 while the command runs. Both clear when it ends, and chip select is high by then.
- R5: Writing a 1 to bit 4 of offset 0x2 sets the buffer pointer to zero. The pointer shows in bits [2:0] of offset 0xD, and bit 4 of offset 0x2 always reads 0.
- R6: Each read or write at offset 0xC accesses the entry under the pointer and then advances the pointer by one, modulo 8.
- R7: With a transmit count t > 0, received byte j is stored at buffer entry (t + j) mod 8.
- R8: With a transmit count of 0, the first received byte is dropped. Received byte j (j ≥ 1) is stored at entry j - 1.
- R9: Chip select stays low for the whole command and high otherwise. SCLK idles low and its period is 2*HALF_DIV system clocks.
- R10: While a command runs, writes to offsets 0x0, 0x1, 0xC and 0x2 have no effect, and reads at 0xC do not move the pointer.
- R11: After reset, chip select is high, SCLK is low, and offsets 0x0, 0x1, 0x2, 0x3 and 0xD read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 4 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rd | input | 1 | Register read strobe (advances the pointer at 0xC) |
| reg_rdata | output | 8 | Register read data, combinational on reg_addr |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The hardest cases to reach from the ports are the ones where the response wraps around the eight-entry buffer. These happen when payload plus kept response exceed eight bytes, and they interact with the dropped first byte when the payload is empty. The bench sweeps every transmit count from 0 to 8, plus one clamped value, against receive counts from 0 to 9. A serial flash model sends a response that differs for each byte, and a bench-side model of the buffer predicts every entry. The busy-time rules are reached by issuing register writes and data-port reads immediately after a start, while the transfer is still in flight. The register and pointer state is read back afterwards.

// File: rtl/spi_cmd_pkg.sv
// Shared constants and types for the SPI command engine.
// Assumes a 4-bit register offset space and byte-wide registers.
package spi_cmd_pkg;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned CNT_W  = 4;

    localparam logic [3:0] OFS_OPCODE = 4'h0;
    localparam logic [3:0] OFS_COUNT  = 4'h1;
    localparam logic [3:0] OFS_CTRL   = 4'h2;
    localparam logic [3:0] OFS_STATUS = 4'h3;
    localparam logic [3:0] OFS_DATA   = 4'hC;
    localparam logic [3:0] OFS_PTR    = 4'hD;

    localparam int unsigned CTRL_GO   = 0;
    localparam int unsigned CTRL_PCLR = 4;
    localparam int unsigned STAT_BUSY = 7;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_LAUNCH,
        SQ_WAIT,
        SQ_FINISH
    } seq_state_e;
endpackage

// File: rtl/spi_cmd_fifo.sv
// Shared payload/response buffer with one host pointer.
// The host side reads and writes at the pointer and advances it.
// The engine side uses its own explicit indices.
// Assumes DEPTH is a power of two and that the host and the engine never write in the same cycle.
module spi_cmd_fifo #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned W     = 8,
    localparam int unsigned PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [W-1:0]  host_wdata,
    output logic [W-1:0]  host_rdata,
    output logic [PW-1:0] ptr,
    input  logic [PW-1:0] eng_rd_idx,
    output logic [W-1:0]  eng_rd_data,
    input  logic          eng_wr,
    input  logic [PW-1:0] eng_wr_idx,
    input  logic [W-1:0]  eng_wr_data
);
    logic [W-1:0] mem [DEPTH];

    // Host pointer: cleared on request, otherwise it steps on each data-port access.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ptr <= '0;
        end else if (host_wr || host_rd) begin
            ptr <= ptr + 1'b1;
        end
    end

    // Storage: one entry per index, written by the host or by the engine.
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (host_wr && ptr == PW'(g)) begin
                mem[g] <= host_wdata;
            end else if (eng_wr && eng_wr_idx == PW'(g)) begin
                mem[g] <= eng_wr_data;
            end
        end
    end

    assign host_rdata  = mem[ptr];
    assign eng_rd_data = mem[eng_rd_idx];

    AST_PTR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ptr == '0); // R5
endmodule

// File: rtl/spi_cmd_shifter.sv
// Byte shifter for SPI mode 0, most significant bit first.
// A start pulse loads one byte. The shifter then sends eight SCLK pulses and raises done for one cycle
// after the last falling edge, with rx_byte holding the sampled byte.
// Assumes start arrives only while the shifter is idle.
module spi_cmd_shifter #(
    parameter int unsigned HALF_DIV = 2,
    localparam int unsigned DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx_byte
);
    logic          active;
    logic [DW-1:0] div_cnt;
    logic [2:0]    bit_cnt;
    logic [7:0]    txsh;

    // Half-period timing, edge generation, sampling on the rising edge and shifting on the falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            div_cnt <= '0;
            bit_cnt <= '0;
            txsh    <= '0;
            rx_byte <= '0;
            sclk    <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                active  <= 1'b1;
                div_cnt <= '0;
                bit_cnt <= '0;
                txsh    <= tx_byte;
                sclk    <= 1'b0;
            end else if (active) begin
                if (div_cnt == DW'(HALF_DIV - 1)) begin
                    div_cnt <= '0;
                    if (!sclk) begin
                        sclk    <= 1'b1;
                        rx_byte <= {rx_byte[6:0], miso};
                    end else begin
                        sclk <= 1'b0;
                        if (bit_cnt == 3'd7) begin
                            active <= 1'b0;
                            done   <= 1'b1;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                            txsh    <= {txsh[6:0], 1'b0};
                        end
                    end
                end else begin
                    div_cnt <= div_cnt + 1'b1;
                end
            end
        end
    end

    assign mosi = txsh[7];

    AST_MOSI_STEADY_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && !$past(sclk)) |-> $stable(mosi)); // R1
    AST_DONE_WITH_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !sclk); // R9
endmodule

// File: rtl/spi_cmd_seq.sv
// Command sequencer. It owns chip select and walks through the bytes of one command:
// the opcode, then the payload from the buffer, then the receive bytes, which are shifted out as zero.
// Kept response bytes go into the buffer right after the payload.
// Assumes the opcode and counts stay unchanged while a command runs.
module spi_cmd_seq
    import spi_cmd_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned PW   = $clog2(DEPTH),
    localparam int unsigned BW   = $clog2(DEPTH + (1 << CNT_W) + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [7:0]       opcode,
    input  logic [CNT_W-1:0] tx_cnt,
    input  logic [CNT_W-1:0] rx_cnt,
    output logic [PW-1:0]    fifo_rd_idx,
    input  logic [7:0]       fifo_rd_data,
    output logic             fifo_wr,
    output logic [PW-1:0]    fifo_wr_idx,
    output logic [7:0]       fifo_wr_data,
    output logic             sh_start,
    output logic [7:0]       sh_byte,
    input  logic             sh_done,
    input  logic [7:0]       sh_rx,
    output logic             cs_n,
    output logic             done
);
    seq_state_e    state;
    logic [BW-1:0] txn, rxn, byte_idx;
    logic [BW-1:0] idx_m1, last_idx, rx_k, store_pos;
    logic [BW-1:0] tx_in;
    logic          drop, is_rx, keep;

    assign tx_in       = BW'(tx_cnt);
    assign idx_m1      = byte_idx - BW'(1);
    assign last_idx    = txn + rxn;
    assign drop        = (txn == '0);
    assign is_rx       = (byte_idx > txn);
    assign rx_k        = byte_idx - txn - BW'(1);
    assign keep        = is_rx && !(drop && rx_k == '0);
    assign store_pos   = txn + rx_k - BW'(drop);
    assign fifo_rd_idx = idx_m1[PW-1:0];

    // Byte-level control: latch the counts, launch each byte, store the kept responses, close the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= SQ_IDLE;
            txn          <= '0;
            rxn          <= '0;
            byte_idx     <= '0;
            cs_n         <= 1'b1;
            sh_start     <= 1'b0;
            sh_byte      <= '0;
            fifo_wr      <= 1'b0;
            fifo_wr_idx  <= '0;
            fifo_wr_data <= '0;
            done         <= 1'b0;
        end else begin
            sh_start <= 1'b0;
            fifo_wr  <= 1'b0;
            done     <= 1'b0;
            unique case (state)
                SQ_IDLE: begin
                    if (go) begin
                        txn      <= (tx_in > BW'(DEPTH)) ? BW'(DEPTH) : tx_in;
                        rxn      <= BW'(rx_cnt);
                        byte_idx <= '0;
                        cs_n     <= 1'b0;
                        state    <= SQ_LAUNCH;
                    end
                end
                SQ_LAUNCH: begin
                    sh_start <= 1'b1;
                    if (byte_idx == '0) begin
                        sh_byte <= opcode;
                    end else if (!is_rx) begin
                        sh_byte <= fifo_rd_data;
                    end else begin
                        sh_byte <= '0;
                    end
                    state <= SQ_WAIT;
                end
                SQ_WAIT: begin
                    if (sh_done) begin
                        if (keep) begin
                            fifo_wr      <= 1'b1;
                            fifo_wr_idx  <= store_pos[PW-1:0];
                            fifo_wr_data <= sh_rx;
                        end
                        if (byte_idx == last_idx) begin
                            state <= SQ_FINISH;
                        end else begin
                            byte_idx <= byte_idx + 1'b1;
                            state    <= SQ_LAUNCH;
                        end
                    end
                end
                SQ_FINISH: begin
                    cs_n  <= 1'b1;
                    done  <= 1'b1;
                    state <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    AST_STORE_AFTER_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> (byte_idx > txn)); // R7
    AST_NO_STORE_OF_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr && txn == '0) |-> (byte_idx > BW'(1))); // R8
endmodule

// File: rtl/spi_cmd_engine.sv
// Top of the SPI flash command engine.
// It decodes the byte registers, gates every write and data-port access while a command runs,
// and joins the buffer, the sequencer and the shifter.
// Assumes reg_rd is asserted only for a real read access, because a read at 0xC moves the pointer.
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 8,
    parameter int unsigned HALF_DIV   = 2,
    localparam int unsigned PW        = $clog2(FIFO_DEPTH)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] reg_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    input  logic       reg_rd,
    output logic [7:0] reg_rdata,
    output logic       spi_sclk,
    output logic       spi_cs_n,
    output logic       spi_mosi,
    input  logic       spi_miso
);
    logic [7:0]       opcode_q, count_q;
    logic             busy_q;
    logic             wr_ok, ctl_wr, go_start, ptr_clr, dat_wr, dat_rd;
    logic [7:0]       fifo_rdata, eng_rd_data, eng_wr_data, sh_byte, sh_rx;
    logic [PW-1:0]    ptr, eng_rd_idx, eng_wr_idx;
    logic             eng_wr, sh_start, sh_done, seq_done;

    assign wr_ok    = reg_wr && !busy_q;
    assign ctl_wr   = wr_ok && reg_addr == OFS_CTRL;
    assign go_start = ctl_wr && reg_wdata[CTRL_GO];
    assign ptr_clr  = ctl_wr && reg_wdata[CTRL_PCLR];
    assign dat_wr   = wr_ok && reg_addr == OFS_DATA;
    assign dat_rd   = reg_rd && !busy_q && reg_addr == OFS_DATA;

    // Opcode and count registers, which only change while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opcode_q <= '0;
            count_q  <= '0;
        end else if (wr_ok) begin
            if (reg_addr == OFS_OPCODE) opcode_q <= reg_wdata;
            if (reg_addr == OFS_COUNT)  count_q  <= reg_wdata;
        end
    end

    // Start bit: set by software, cleared when the sequencer finishes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
        end else if (go_start) begin
            busy_q <= 1'b1;
        end else if (seq_done) begin
            busy_q <= 1'b0;
        end
    end

    // Read multiplexer over the register offsets.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_OPCODE: reg_rdata = opcode_q;
            OFS_COUNT:  reg_rdata = count_q;
            OFS_CTRL:   reg_rdata[CTRL_GO]   = busy_q;
            OFS_STATUS: reg_rdata[STAT_BUSY] = busy_q;
            OFS_DATA:   reg_rdata = fifo_rdata;
            OFS_PTR:    reg_rdata = 8'(ptr);
            default:    reg_rdata = '0;
        endcase
    end

    spi_cmd_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) fifo_i (
        .clk(clk), .rst_n(rst_n), .clr(ptr_clr),
        .host_wr(dat_wr), .host_rd(dat_rd), .host_wdata(reg_wdata),
        .host_rdata(fifo_rdata), .ptr(ptr),
        .eng_rd_idx(eng_rd_idx), .eng_rd_data(eng_rd_data),
        .eng_wr(eng_wr), .eng_wr_idx(eng_wr_idx), .eng_wr_data(eng_wr_data)
    );

    spi_cmd_seq #(.DEPTH(FIFO_DEPTH)) seq_i (
        .clk(clk), .rst_n(rst_n), .go(go_start), .opcode(opcode_q),
        .tx_cnt(count_q[3:0]), .rx_cnt(count_q[7:4]),
        .fifo_rd_idx(eng_rd_idx), .fifo_rd_data(eng_rd_data),
        .fifo_wr(eng_wr), .fifo_wr_idx(eng_wr_idx), .fifo_wr_data(eng_wr_data),
        .sh_start(sh_start), .sh_byte(sh_byte), .sh_done(sh_done), .sh_rx(sh_rx),
        .cs_n(spi_cs_n), .done(seq_done)
    );

    spi_cmd_shifter #(.HALF_DIV(HALF_DIV)) shift_i (
        .clk(clk), .rst_n(rst_n), .start(sh_start), .tx_byte(sh_byte),
        .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi),
        .done(sh_done), .rx_byte(sh_rx)
    );

    AST_CS_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> busy_q); // R9
    AST_SCLK_LOW_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk); // R9
    AST_CS_HIGH_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && $past(busy_q)) |-> spi_cs_n); // R4
    AST_REGS_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q)) |-> ($stable(opcode_q) && $stable(count_q) && $stable(ptr))); // R10
endmodule

// File: tb/spi_cmd_engine_tb_top.sv
// Self-checking bench: a flash model on the serial pins, a model of the buffer,
// and sweeps over the transmit and receive counts.
module spi_cmd_engine_tb_top;
    localparam int HALF_DIV  = 2;
    localparam int WATCHDOG  = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_rdata;
    logic       spi_sclk, spi_cs_n, spi_mosi;
    logic       spi_miso = 1'b0;

    int checks = 0;
    int errors = 0;

    // 250 MHz clock: 4 time units per period.
    always #2 clk = ~clk;

    spi_cmd_engine #(.FIFO_DEPTH(8), .HALF_DIV(HALF_DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    // ---------------- flash model ----------------
    int         cyc = 0;
    int         cs_falls = 0;
    int         nbyte = 0;
    int         bitn_r = 0;
    int         bitn_f = 0;
    int         last_rise = 0;
    int         rise_gap = 0;
    int         stray_edges = 0;
    logic [7:0] mosi_sh = '0;
    logic [7:0] mosi_log [32];
    logic [7:0] resp_seed = '0;

    function automatic logic [7:0] resp(input int n, input logic [7:0] seed);
        logic [7:0] v;
        v = 8'(n * 37) + seed;
        return v ^ 8'h5A;
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge spi_cs_n) begin
        cs_falls++;
        nbyte  = 0;
        bitn_r = 0;
        bitn_f = 0;
        spi_miso = resp(0, resp_seed)[7];
    end

    always @(posedge spi_sclk) begin
        if (spi_cs_n) begin
            stray_edges++;
        end else begin
            if (bitn_r != 0) rise_gap = cyc - last_rise;
            last_rise = cyc;
            mosi_sh = {mosi_sh[6:0], spi_mosi};
            bitn_r++;
            if (bitn_r == 8) begin
                if (nbyte < 32) mosi_log[nbyte] = mosi_sh;
                nbyte++;
                bitn_r = 0;
            end
        end
    end

    always @(negedge spi_sclk) begin
        if (!spi_cs_n) begin
            bitn_f = (bitn_f + 1) % 8;
            spi_miso = resp(nbyte, resp_seed)[7 - bitn_f];
        end
    end

    // ---------------- buffer model ----------------
    logic [7:0] mdl [8];
    int         bptr = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr_data(input logic [7:0] b);
        reg_write(4'hC, b);
        mdl[bptr] = b;
        bptr = (bptr + 1) % 8;
    endtask

    task automatic ptr_reset();
        reg_write(4'h2, 8'h10);
        bptr = 0;
    endtask

    function automatic logic [7:0] pay(input logic [7:0] opc, input int i);
        return opc ^ 8'(i * 29 + 7);
    endfunction

    // Wait for the end of a command, then check the bus traffic and the buffer contents.
    task automatic finish_cmd(input logic [7:0] opc, input int txf, input int rx, input int falls0);
        logic [7:0] v;
        int txe, drop, kept, bad;
        txe  = (txf > 8) ? 8 : txf;
        drop = (txe == 0) ? 1 : 0;
        v = 8'h80;
        for (int k = 0; k < 4000 && v[7]; k++) reg_read(4'h3, v);
        check("R4 busy cleared", 32'(v[7]), 0);
        reg_read(4'h2, v);
        check("R4 start bit cleared", 32'(v[0]), 0);
        check("R4 cs high after end", 32'(spi_cs_n), 1);
        check("R9 one frame", cs_falls - falls0, 1);
        check("R2 bytes on bus", nbyte, 1 + txe + rx);
        check("R1 opcode first", 32'(mosi_log[0]), 32'(opc));
        bad = 0;
        for (int i = 0; i < txe; i++)
            if (mosi_log[1 + i] !== mdl[i]) bad++;
        check("R3 payload bytes", bad, 0);
        kept = rx - drop;
        for (int j = 0; j < kept; j++)
            mdl[(txe + j) % 8] = resp(1 + txe + drop + j, resp_seed);
        ptr_reset();
        bad = 0;
        for (int i = 0; i < 8; i++) begin
            reg_read(4'hC, v);
            if (v !== mdl[i]) begin
                bad++;
                $display("FAIL %s: entry %0d actual %0h expected %0h",
                         drop ? "R8" : "R7", i, v, mdl[i]);
            end
        end
        checks++;
        if (bad != 0) errors++;
    endtask

    task automatic run_cmd(input logic [7:0] opc, input int txf, input int rx, input logic [7:0] seed);
        logic [7:0] v;
        int f0;
        ptr_reset();
        for (int i = 0; i < 8; i++) wr_data(pay(opc, i));
        resp_seed = seed;
        reg_write(4'h0, opc);
        reg_write(4'h1, {4'(rx), 4'(txf)});
        f0 = cs_falls;
        reg_write(4'h2, 8'h01);
        reg_read(4'h2, v);
        check("R4 start bit reads 1 while running", 32'(v[0]), 1);
        finish_cmd(opc, txf, rx, f0);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int f0;
        for (int i = 0; i < 8; i++) mdl[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state.
        check("R11 cs high", 32'(spi_cs_n), 1);
        check("R11 sclk low", 32'(spi_sclk), 0);
        reg_read(4'h0, v); check("R11 opcode reg", 32'(v), 0);
        reg_read(4'h1, v); check("R11 count reg", 32'(v), 0);
        reg_read(4'h2, v); check("R11 ctrl reg", 32'(v), 0);
        reg_read(4'h3, v); check("R11 status reg", 32'(v), 0);
        reg_read(4'hD, v); check("R11 pointer", 32'(v), 0);

        // R6: pointer steps on writes and reads and wraps modulo 8.
        for (int i = 0; i < 3; i++) wr_data(8'(i + 1));
        reg_read(4'hD, v); check("R6 pointer after 3 writes", 32'(v), 3);
        for (int i = 0; i < 6; i++) wr_data(8'(i + 4));
        reg_read(4'hD, v); check("R6 pointer wraps after 9 writes", 32'(v), 1);
        // R5: pointer reset, self-clearing bit.
        ptr_reset();
        reg_read(4'hD, v); check("R5 pointer cleared", 32'(v), 0);
        reg_read(4'h2, v); check("R5 clear bit reads 0", 32'(v[4]), 0);
        reg_read(4'hC, v); check("R6 entry 0 read", 32'(v), 32'(mdl[0]));
        reg_read(4'hC, v); check("R6 entry 1 read", 32'(v), 32'(mdl[1]));
        reg_read(4'hD, v); check("R6 pointer after 2 reads", 32'(v), 2);

        // R2 R3 R7 R8: sweep transmit 0..8 plus a clamped 12, receive 0..9.
        for (int t = 0; t <= 9; t++) begin
            for (int r = 0; r <= 9; r++) begin
                run_cmd(8'(8'h03 + t * 16 + r), (t == 9) ? 12 : t, r, 8'(t * 11 + r * 5));
            end
        end
        check("R9 sclk period in clocks", rise_gap, 2 * HALF_DIV);
        check("R9 no sclk edge while deselected", stray_edges, 0);

        // R10: accesses while busy are ignored.
        ptr_reset();
        for (int i = 0; i < 11; i++) wr_data(pay(8'h9B, i));
        resp_seed = 8'h44;
        reg_write(4'h0, 8'h9B);
        reg_write(4'h1, 8'h62);
        f0 = cs_falls;
        reg_write(4'h2, 8'h01);
        reg_write(4'h0, 8'hEE);
        reg_write(4'h1, 8'h11);
        reg_write(4'hC, 8'h77);
        reg_write(4'h2, 8'h11);
        reg_read(4'hC, v);
        reg_read(4'hD, v);
        check("R10 pointer frozen while busy", 32'(v), 3);
        check("R10 still busy during probes", 32'(spi_cs_n), 0);
        v = 8'h80;
        for (int k = 0; k < 4000 && v[7]; k++) reg_read(4'h3, v);
        reg_read(4'h0, v); check("R10 opcode write ignored", 32'(v), 32'h9B);
        reg_read(4'h1, v); check("R10 count write ignored", 32'(v), 32'h62);
        reg_read(4'hD, v); check("R10 pointer unchanged after busy", 32'(v), 3);
        check("R10 restart ignored", cs_falls - f0, 1);
        check("R10 frame length", nbyte, 9);
        check("R1 opcode first in R10 case", 32'(mosi_log[0]), 32'h9B);
        for (int j = 0; j < 6; j++) mdl[(2 + j) % 8] = resp(3 + j, resp_seed);
        ptr_reset();
        for (int i = 0; i < 8; i++) begin
            reg_read(4'hC, v);
            check("R10 buffer after ignored data write", 32'(v), 32'(mdl[i]));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule